// File: doc/BRIEF.md
# Ingress Address Decoder with Remap

This block sits where a master's request enters an on-chip interconnect and turns its 48-bit address into a destination ID for the routing fabric. It compares the address against a fixed table of decoded target ranges and against a small set of programmable remap entries. A master may also supply its own destination ID. Three wide regions (an accelerator array and two programmable-logic windows) have no decoder of their own. They depend on remap entries or on a master-supplied ID. Without either, they are still routed, toward a designated error-slave destination.

An address that resolves nowhere and lies outside the three wide regions gets a decode-error response and is not routed. The same case sets a sticky interrupt status bit, which software clears by writing a one. Remap entries and the status clear share one small register write port. Every result is registered and appears one cycle after the request strobe.

Top module: `ingress_addr_decoder`

## Requirements
- R1: A request strobed on `req_valid` at one rising edge produces `rsp_vld`=1 with its result after that edge. `rsp_vld`, `route_vld` and `decerr` are 0 after an edge without a request.
- R2: With no remap hit and `mst_id_en`=0, an address inside fixed range k routes with `dest_id` = FIX_ID_BASE + k. The fixed ranges are:
  - k=0: 0x0000_0000_0000–0x0000_7FFF_FFFF
  - k=1: 0x0000_8000_0000–0x0000_9FFF_FFFF
  - k=2: 0x0000_A400_0000–0x0000_AFFF_FFFF
  - k=3: 0x0000_B000_0000–0x0000_BFFF_FFFF
  - k=4: 0x0000_C000_0000–0x0000_DFFF_FFFF
  - k=5: 0x0000_E000_0000–0x0000_EFFF_FFFF
  - k=6: 0x0000_F000_0000–0x0000_F7FF_FFFF
  - k=7: 0x0000_F800_0000–0x0000_F90F_FFFF
  - k=8: 0x0000_FC00_0000–0x0000_FCFF_FFFF
  - k=9: 0x0000_FD00_0000–0x0000_FDFF_FFFF
  - k=10: 0x0000_FE00_0000–0x0000_FFFF_FFFF
  - k=11: 0x0008_0000_0000–0x000F_FFFF_FFFF
  - k=12: 0x0040_0000_0000–0x0047_FFFF_FFFF
  - k=13: 0x00C0_0000_0000–0x00FF_FFFF_FFFF
  - k=14: 0x0100_0000_0000–0x01B7_7FFF_FFFF
- R3: The range 0x0500_0000_0000–0x07FF_FFFF_FFFF is split into six 0x80_0000_0000-byte halves, k=15..20 in ascending address order. Each half has its own ID, so the two halves of one channel get different IDs.
- R4: Remap entry i hits when it is enabled and (addr XOR base) AND mask is zero. A hit sets `dest_id` to the entry's ID and takes priority over the master ID and the fixed table. Among several hits, the lowest index wins.
- R5: With no remap hit and `mst_id_en`=1, the request routes with `dest_id`=`mst_id` in any region, ahead of the fixed table.
- R6: Three wide regions have no decoder: 0x0200_0000_0000–0x0200_3FFF_FFFF, 0x0201_0000_0000–0x03FF_FFFF_FFFF and 0x0800_0000_0000–0x0FFF_FFFF_FFFF. A request there with no remap hit and no master ID routes with `dest_id`=ERR_ID and `decerr`=0.
- R7: An address that resolves nowhere and lies outside the R6 regions gives `decerr`=1 and `route_vld`=0.
- R8: Each R7 case sets `irq_stat`, which then stays 1 through later requests.
- R9: A write to `cfg_addr` field 3 (`cfg_addr[1:0]`=3) with `cfg_wdata[0]`=1 clears `irq_stat`; with `cfg_wdata[0]`=0 it leaves `irq_stat` unchanged. A new R7 case in the same cycle as a clear leaves `irq_stat` set.
- R10: Remap writes select the entry with `cfg_addr[3:2]` and the field with `cfg_addr[1:0]`: 0 = base (wdata[47:0]), 1 = mask (wdata[47:0]), 2 = control (ID in wdata[IDW-1:0], enable in wdata[31]). A disabled entry never hits, even when its base and mask would match.
- R11: After reset, all outputs are 0 and every remap entry is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 48 | Request address |
| mst_id_en | input | 1 | Master-supplied ID is valid |
| mst_id | input | IDW | Master-supplied destination ID |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | log2(N_REMAP)+2 | Entry index (high bits) and field (low 2 bits) |
| cfg_wdata | input | 48 | Register write data |
| rsp_vld | output | 1 | Result valid, one cycle after the request |
| route_vld | output | 1 | Request is injected with `dest_id` |
| decerr | output | 1 | Decode error, request not routed |
| dest_id | output | IDW | Resolved destination ID |
| irq_stat | output | 1 | Sticky address-map error status |

## Verification
Every decode result is due exactly one clock after the edge that captured `req_valid`. The bench drives each request on a falling edge and deasserts it at the next falling edge. It then reads all outputs at that point, half a period after the capturing edge. Register writes take effect at the edge that captures them, so a write is always followed by a request one cycle later. `irq_stat` changes at the same edge as the response that sets it, so it is compared in the same sample, including in the cycle where a set and a clear collide.

// File: rtl/ingress_addr_decoder.sv
module ingress_addr_decoder #(
  parameter int IDW         = 12,
  parameter int N_REMAP     = 4,
  parameter int FIX_ID_BASE = 16,
  parameter int ERR_ID      = 4095
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [47:0]             req_addr,
  input  logic                    mst_id_en,
  input  logic [IDW-1:0]          mst_id,
  input  logic                    cfg_we,
  input  logic [(N_REMAP>1 ? $clog2(N_REMAP) : 1)+1:0] cfg_addr,
  input  logic [47:0]             cfg_wdata,
  output logic                    rsp_vld,
  output logic                    route_vld,
  output logic                    decerr,
  output logic [IDW-1:0]          dest_id,
  output logic                    irq_stat
);
  localparam int EW   = N_REMAP > 1 ? $clog2(N_REMAP) : 1;
  localparam int CAW  = EW + 2;
  localparam int NFIX = 21;

  localparam logic [47:0] FLO [NFIX] = '{
    48'h0000_0000_0000, 48'h0000_8000_0000, 48'h0000_A400_0000, 48'h0000_B000_0000,
    48'h0000_C000_0000, 48'h0000_E000_0000, 48'h0000_F000_0000, 48'h0000_F800_0000,
    48'h0000_FC00_0000, 48'h0000_FD00_0000, 48'h0000_FE00_0000, 48'h0008_0000_0000,
    48'h0040_0000_0000, 48'h00C0_0000_0000, 48'h0100_0000_0000, 48'h0500_0000_0000,
    48'h0580_0000_0000, 48'h0600_0000_0000, 48'h0680_0000_0000, 48'h0700_0000_0000,
    48'h0780_0000_0000};
  localparam logic [47:0] FHI [NFIX] = '{
    48'h0000_7FFF_FFFF, 48'h0000_9FFF_FFFF, 48'h0000_AFFF_FFFF, 48'h0000_BFFF_FFFF,
    48'h0000_DFFF_FFFF, 48'h0000_EFFF_FFFF, 48'h0000_F7FF_FFFF, 48'h0000_F90F_FFFF,
    48'h0000_FCFF_FFFF, 48'h0000_FDFF_FFFF, 48'h0000_FFFF_FFFF, 48'h000F_FFFF_FFFF,
    48'h0047_FFFF_FFFF, 48'h00FF_FFFF_FFFF, 48'h01B7_7FFF_FFFF, 48'h057F_FFFF_FFFF,
    48'h05FF_FFFF_FFFF, 48'h067F_FFFF_FFFF, 48'h06FF_FFFF_FFFF, 48'h077F_FFFF_FFFF,
    48'h07FF_FFFF_FFFF};

  logic [47:0]    rm_base [N_REMAP];
  logic [47:0]    rm_mask [N_REMAP];
  logic [IDW-1:0] rm_dest [N_REMAP];
  logic [N_REMAP-1:0] rm_en;

  wire [1:0]    cfg_fld  = cfg_addr[1:0];
  wire [EW-1:0] cfg_ent  = cfg_addr[CAW-1:2];
  wire          irq_clr  = cfg_we && cfg_fld == 2'd3 && cfg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_REMAP; i++) begin
        rm_base[i] <= '0;
        rm_mask[i] <= '0;
        rm_dest[i] <= '0;
      end
      rm_en <= '0;
    end else if (cfg_we) begin
      for (int i = 0; i < N_REMAP; i++) begin
        if (cfg_ent == EW'(i)) begin
          case (cfg_fld)
            2'd0: rm_base[i] <= cfg_wdata;
            2'd1: rm_mask[i] <= cfg_wdata;
            2'd2: begin
              rm_dest[i] <= cfg_wdata[IDW-1:0];
              rm_en[i]   <= cfg_wdata[31];
            end
            default: ;
          endcase
        end
      end
    end
  end

  logic           rm_hit, fx_hit;
  logic [IDW-1:0] rm_id, fx_id;

  always_comb begin
    rm_hit = 1'b0;
    rm_id  = '0;
    for (int i = N_REMAP - 1; i >= 0; i--) begin
      if (rm_en[i] && ((req_addr ^ rm_base[i]) & rm_mask[i]) == '0) begin
        rm_hit = 1'b1;
        rm_id  = rm_dest[i];
      end
    end
  end

  always_comb begin
    fx_hit = 1'b0;
    fx_id  = '0;
    for (int k = 0; k < NFIX; k++) begin
      if (req_addr >= FLO[k] && req_addr <= FHI[k]) begin
        fx_hit = 1'b1;
        fx_id  = IDW'(FIX_ID_BASE + k);
      end
    end
  end

  wire sp_hit = (req_addr >= 48'h0200_0000_0000 && req_addr <= 48'h0200_3FFF_FFFF) ||
                (req_addr >= 48'h0201_0000_0000 && req_addr <= 48'h03FF_FFFF_FFFF) ||
                (req_addr >= 48'h0800_0000_0000 && req_addr <= 48'h0FFF_FFFF_FFFF);

  wire            miss   = !rm_hit && !mst_id_en && !fx_hit && !sp_hit;
  wire [IDW-1:0]  nxt_id = rm_hit    ? rm_id  :
                           mst_id_en ? mst_id :
                           fx_hit    ? fx_id  :
                           sp_hit    ? IDW'(ERR_ID) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_vld   <= 1'b0;
      route_vld <= 1'b0;
      decerr    <= 1'b0;
      dest_id   <= '0;
      irq_stat  <= 1'b0;
    end else begin
      rsp_vld   <= req_valid;
      route_vld <= req_valid && !miss;
      decerr    <= req_valid && miss;
      if (req_valid) dest_id <= nxt_id;
      if (req_valid && miss) irq_stat <= 1'b1;
      else if (irq_clr)      irq_stat <= 1'b0;
    end
  end

  assert_one_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_vld);
  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_vld && !route_vld && !decerr);
  assert_err_no_route_R7: assert property (@(posedge clk) disable iff (!rst_n)
    decerr |-> !route_vld && rsp_vld);
  assert_irq_on_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    decerr |-> irq_stat);
  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_stat && !irq_clr |=> irq_stat);
  assert_irq_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr && !req_valid |=> !irq_stat);
endmodule

// File: tb/test_ingress_addr_decoder.sv
module test_ingress_addr_decoder;
  localparam int IDW = 12;
  localparam int FIXB = 16;
  localparam int ERRID = 4095;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, mst_id_en = 0, cfg_we = 0;
  logic [47:0] req_addr = '0, cfg_wdata = '0;
  logic [IDW-1:0] mst_id = '0;
  logic [3:0] cfg_addr = '0;
  logic rsp_vld, route_vld, decerr, irq_stat;
  logic [IDW-1:0] dest_id;
  int checks = 0, errors = 0;
  logic exp_irq = 0;

  always #10 clk = ~clk;

  ingress_addr_decoder #(.IDW(IDW), .N_REMAP(4), .FIX_ID_BASE(FIXB), .ERR_ID(ERRID)) i_ingress_addr_decoder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .mst_id_en(mst_id_en), .mst_id(mst_id), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .rsp_vld(rsp_vld), .route_vld(route_vld), .decerr(decerr),
    .dest_id(dest_id), .irq_stat(irq_stat));

  localparam logic [47:0] LO [24] = '{
    48'h0000_0000_0000, 48'h0000_8000_0000, 48'h0000_A400_0000, 48'h0000_B000_0000,
    48'h0000_C000_0000, 48'h0000_E000_0000, 48'h0000_F000_0000, 48'h0000_F800_0000,
    48'h0000_FC00_0000, 48'h0000_FD00_0000, 48'h0000_FE00_0000, 48'h0008_0000_0000,
    48'h0040_0000_0000, 48'h00C0_0000_0000, 48'h0100_0000_0000, 48'h0500_0000_0000,
    48'h0580_0000_0000, 48'h0600_0000_0000, 48'h0680_0000_0000, 48'h0700_0000_0000,
    48'h0780_0000_0000, 48'h0200_0000_0000, 48'h0201_0000_0000, 48'h0800_0000_0000};
  localparam logic [47:0] HI [24] = '{
    48'h0000_7FFF_FFFF, 48'h0000_9FFF_FFFF, 48'h0000_AFFF_FFFF, 48'h0000_BFFF_FFFF,
    48'h0000_DFFF_FFFF, 48'h0000_EFFF_FFFF, 48'h0000_F7FF_FFFF, 48'h0000_F90F_FFFF,
    48'h0000_FCFF_FFFF, 48'h0000_FDFF_FFFF, 48'h0000_FFFF_FFFF, 48'h000F_FFFF_FFFF,
    48'h0047_FFFF_FFFF, 48'h00FF_FFFF_FFFF, 48'h01B7_7FFF_FFFF, 48'h057F_FFFF_FFFF,
    48'h05FF_FFFF_FFFF, 48'h067F_FFFF_FFFF, 48'h06FF_FFFF_FFFF, 48'h077F_FFFF_FFFF,
    48'h07FF_FFFF_FFFF, 48'h0200_3FFF_FFFF, 48'h03FF_FFFF_FFFF, 48'h0FFF_FFFF_FFFF};

  task automatic chk(input string tag, input logic [47:0] got, input logic [47:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cfg_wr(input logic [3:0] a, input logic [47:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic req(input string tag, input logic [47:0] a, input logic men, input logic [IDW-1:0] mid,
                     input logic e_route, input logic e_err, input logic [IDW-1:0] e_id);
    @(negedge clk);
    req_valid = 1; req_addr = a; mst_id_en = men; mst_id = mid;
    @(negedge clk);
    req_valid = 0; mst_id_en = 0;
    if (e_err) exp_irq = 1;
    chk({tag, " R1 rsp_vld"}, 48'(rsp_vld), 48'd1);
    chk({tag, " route_vld"}, 48'(route_vld), 48'(e_route));
    chk({tag, " R7 decerr"}, 48'(decerr), 48'(e_err));
    if (e_route) chk({tag, " dest_id"}, 48'(dest_id), 48'(e_id));
    chk({tag, " R8 irq_stat"}, 48'(irq_stat), 48'(exp_irq));
  endtask

  function automatic int region_of(input logic [47:0] a);
    for (int k = 0; k < 24; k++) if (a >= LO[k] && a <= HI[k]) return k;
    return -1;
  endfunction

  task automatic probe(input logic [47:0] a);
    int r;
    r = region_of(a);
    if (r < 0)       req("R7 unmapped", a, 0, '0, 0, 1, '0);
    else if (r < 15) req("R2 fixed", a, 0, '0, 1, 0, IDW'(FIXB + r));
    else if (r < 21) req("R3 half", a, 0, '0, 1, 0, IDW'(FIXB + r));
    else             req("R6 special", a, 0, '0, 1, 0, IDW'(ERRID));
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 rsp_vld", 48'(rsp_vld), 0);
    chk("R11 route_vld", 48'(route_vld), 0);
    chk("R11 decerr", 48'(decerr), 0);
    chk("R11 irq_stat", 48'(irq_stat), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle", 48'(rsp_vld), 0);

    for (int k = 0; k < 24; k++) begin
      probe(LO[k]);
      probe(HI[k]);
      probe(LO[k] + (HI[k] - LO[k]) / 2);
      probe(HI[k] + 1);
      if (LO[k] != 0) probe(LO[k] - 1);
    end
    probe(48'hFFFF_FFFF_FFFF);
    probe(48'h0001_0000_0000);
    @(negedge clk);
    chk("R1 idle after sweep", 48'({rsp_vld, route_vld, decerr}), 0);

    req("R3 ch1 low", 48'h057F_FFFF_FFF0, 0, '0, 1, 0, IDW'(FIXB + 15));
    req("R3 ch1 high", 48'h0580_0000_0010, 0, '0, 1, 0, IDW'(FIXB + 16));

    cfg_wr(4'b00_00, 48'h0201_4000_0000);
    cfg_wr(4'b00_01, 48'hFFFF_C000_0000);
    cfg_wr(4'b00_10, 48'h0000_0000_0077);
    req("R10 disabled entry", 48'h0201_4000_1234, 0, '0, 1, 0, IDW'(ERRID));
    cfg_wr(4'b01_00, 48'h0201_4000_0000);
    cfg_wr(4'b01_01, 48'hFFFF_C000_0000);
    cfg_wr(4'b01_10, 48'h0000_8000_0055);
    cfg_wr(4'b10_00, 48'h0201_0000_0000);
    cfg_wr(4'b10_01, 48'hFFFF_0000_0000);
    cfg_wr(4'b10_10, 48'h0000_8000_0066);
    req("R4 lowest index wins", 48'h0201_4000_1234, 0, '0, 1, 0, 12'h055);
    req("R4 wider entry", 48'h0201_8000_0000, 0, '0, 1, 0, 12'h066);
    req("R4 beats master id", 48'h0201_7FFF_FFFF, 1, 12'h0AB, 1, 0, 12'h055);
    cfg_wr(4'b00_10, 48'h0000_8000_0077);
    req("R4 entry0 enabled", 48'h0201_4000_1234, 0, '0, 1, 0, 12'h077);
    cfg_wr(4'b11_00, 48'h0500_0000_0000);
    cfg_wr(4'b11_01, 48'hFFFF_FFFF_F000);
    cfg_wr(4'b11_10, 48'h0000_8000_0088);
    req("R4 beats fixed", 48'h0500_0000_0100, 0, '0, 1, 0, 12'h088);
    req("R4 outside window", 48'h0500_0000_1000, 0, '0, 1, 0, IDW'(FIXB + 15));

    req("R5 special", 48'h0900_0000_0000, 1, 12'h0AB, 1, 0, 12'h0AB);
    req("R5 fixed", 48'h0040_0000_0000, 1, 12'h0CD, 1, 0, 12'h0CD);
    req("R5 unmapped", 48'h0020_0000_0000, 1, 12'h0EF, 1, 0, 12'h0EF);
    req("R6 no master id", 48'h0900_0000_0000, 0, '0, 1, 0, IDW'(ERRID));

    chk("R8 sticky", 48'(irq_stat), 1);
    cfg_wr(4'b00_11, 48'h0);
    chk("R9 clear bit0=0", 48'(irq_stat), 1);
    req("R10 entry0 after field3 write", 48'h0201_4000_1234, 0, '0, 1, 0, 12'h077);
    cfg_wr(4'b00_11, 48'h1);
    exp_irq = 0;
    chk("R9 clear bit0=1", 48'(irq_stat), 0);
    req("R8 mapped keeps clear", 48'h0000_0000_1000, 0, '0, 1, 0, IDW'(FIXB));
    req("R8 set again", 48'h0000_A000_0000, 0, '0, 0, 1, '0);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 4'b00_11; cfg_wdata = 48'h1;
    req_valid = 1; req_addr = 48'h0000_F950_0000; mst_id_en = 0;
    @(negedge clk);
    cfg_we = 0; req_valid = 0;
    chk("R9 set wins over clear", 48'(irq_stat), 1);
    chk("R7 collide decerr", 48'(decerr), 1);
    cfg_wr(4'b10_11, 48'h1);
    chk("R9 clear via other entry", 48'(irq_stat), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule